// File: doc/BRIEF.md
# Receive Checksum and Status Record Generator

This block sits on the receive path of an Ethernet MAC, behind the address filter. It watches each accepted frame as a byte stream. While the bytes pass, it adds up a 16-bit ones'-complement partial checksum over everything after the 14-byte Ethernet header. When the frame's last byte arrives, it folds the sum and packs it into a five-word status record. The frame's reported length and the filter's class flags go into the same record.

The record is presented on a sideband control stream, marked by a one-cycle valid strobe. A receive-complete pulse follows one cycle later, once the record has been handed downstream. A 64-bit running count of received bytes accumulates the reported length of every frame and is exposed as low and high 32-bit halves. Frame storage, FCS checking and address matching belong to neighbouring blocks. The buffer size that bounds the stored frame is a parameter.

Top module: `rxcs_status_gen`

## Requirements
- R1: Bytes at offsets 14 and above are summed as big-endian 16-bit pairs into a 32-bit accumulator: the byte at an even distance from offset 14 is the high byte and the next byte is the low byte. Header bytes at offsets 0 to 13 contribute nothing.
- R2: When the summed region has an odd number of bytes, the final byte is added as a high byte with a zero low byte.
- R3: The accumulator is folded by adding its upper 16 bits to its lower 16 bits, and that fold is applied a second time to absorb any carry. The 16-bit result appears in status word 3 bits 31:16, and word 3 bits 15:0 are zero.
- R4: The stored length is the frame's byte count, capped at BUF_BYTES minus 4. Bytes beyond the cap are not summed. Status word 4 carries the reported length in bits 15:0, with bits 31:16 zero.
- R5: When fcs_inband is high with the last byte, the reported length is the stored length plus 4. The checksum is unchanged.
- R6: Status word 2 bit 0 equals the multicast flag, and bit 1 is set only when both the multicast and IP-multicast flags are high. All other bits of word 2 are zero, and words 0 and 1 are zero. The flags are sampled with the last byte.
- R7: stat_valid is a one-cycle pulse in the second cycle after the last byte is accepted, and the record holds its value until the next record. rx_cmplt is a one-cycle pulse in the cycle after stat_valid.
- R8: The 64-bit received-byte count starts at zero. It adds each frame's reported length in the same cycle that rx_cmplt is high, and is readable as rx_bytes_lo (bits 31:0) and rx_bytes_hi (bits 63:32).
- R9: After reset, stat_valid and rx_cmplt are low, all five status words are zero and the byte count is zero.
- R10: A frame may start in the cycle right after the previous frame's last byte. A frame of 14 bytes or fewer reports checksum 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_mcast | input | 1 | Filter class: multicast frame |
| in_ipmcast | input | 1 | Filter class: IP-multicast destination |
| fcs_inband | input | 1 | FCS is passed in band, so 4 is added to the reported length |
| stat_valid | output | 1 | The status record is valid this cycle |
| stat_w0 | output | 32 | Status word 0 |
| stat_w1 | output | 32 | Status word 1 |
| stat_w2 | output | 32 | Status word 2, the class flags |
| stat_w3 | output | 32 | Status word 3, the checksum in the upper half |
| stat_w4 | output | 32 | Status word 4, the length in the lower half |
| rx_cmplt | output | 1 | Receive-complete pulse |
| rx_bytes_lo | output | 32 | Received-byte count, low half |
| rx_bytes_hi | output | 32 | Received-byte count, high half |

## Verification
The checksum, length and flags of a frame are due in the second cycle after its last byte is sampled. The receive-complete pulse and the updated byte count are due one cycle after that. The bench's reference model stamps each expected record with the cycle number at which it is due. On every falling edge it compares stat_valid, rx_cmplt and the byte count against that schedule, so an early, late or missing strobe is reported in the very cycle it happens. The record's fields are compared only in the cycle the strobe is due, which covers the back-to-back, truncated and short frames as well.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;
  localparam int NWORDS = 5;
  localparam int LEN_W  = 16;
  localparam int WORD_W = 32;
  localparam int ACC_W  = 32;

  typedef struct packed {
    logic mcast;
    logic ipmc;
    logic fcs;
  } rx_class_t;

  typedef logic [NWORDS-1:0][WORD_W-1:0] rec_t;
endpackage

// File: rtl/rxcs_sum.sv
module rxcs_sum
  import rxcs_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int HDR_BYTES = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  rx_class_t        cls_in,
  output logic             fin_vld,
  output logic [ACC_W-1:0] fin_sum,
  output logic [LEN_W-1:0] fin_len,
  output rx_class_t        fin_cls
);
  localparam int CAP = BUF_BYTES - 4;
  localparam int PW  = $clog2(BUF_BYTES + 1);
  localparam bit HPAR = (HDR_BYTES % 2) == 1;

  logic [PW-1:0]    pos_q, pos_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             keep, in_range, hi_slot;
  logic [ACC_W-1:0] addend, acc_sum;
  logic             fin_vld_d;
  logic [ACC_W-1:0] fin_sum_d;
  logic [LEN_W-1:0] fin_len_d;
  rx_class_t        fin_cls_d;

  always_comb begin
    keep     = pos_q < PW'(CAP);
    in_range = keep && (pos_q >= PW'(HDR_BYTES));
    hi_slot  = (pos_q[0] == HPAR);
    if (!in_range)    addend = '0;
    else if (hi_slot) addend = {16'h0, in_data, 8'h0};
    else              addend = {24'h0, in_data};
    acc_sum = acc_q + addend;
  end

  always_comb begin
    pos_d     = pos_q;
    acc_d     = acc_q;
    fin_vld_d = 1'b0;
    fin_sum_d = fin_sum;
    fin_len_d = fin_len;
    fin_cls_d = fin_cls;
    if (in_valid) begin
      if (in_last) begin
        pos_d     = '0;
        acc_d     = '0;
        fin_vld_d = 1'b1;
        fin_sum_d = acc_sum;
        fin_len_d = LEN_W'(pos_q) + LEN_W'(keep);
        fin_cls_d = cls_in;
      end else begin
        acc_d = acc_sum;
        if (keep) pos_d = pos_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      acc_q   <= '0;
      fin_vld <= 1'b0;
      fin_sum <= '0;
      fin_len <= '0;
      fin_cls <= '0;
    end else begin
      pos_q   <= pos_d;
      acc_q   <= acc_d;
      fin_vld <= fin_vld_d;
      fin_sum <= fin_sum_d;
      fin_len <= fin_len_d;
      fin_cls <= fin_cls_d;
    end
  end

  // R4
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= PW'(CAP));

  // R7
  fin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_vld |-> $past(in_valid && in_last));
endmodule

// File: rtl/rxcs_fold.sv
module rxcs_fold
  import rxcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin_vld,
  input  logic [ACC_W-1:0] fin_sum,
  input  logic [LEN_W-1:0] fin_len,
  input  rx_class_t        fin_cls,
  output logic             rec_vld,
  output rec_t             rec,
  output logic [LEN_W-1:0] rep_len
);
  logic [16:0]      fold1;
  logic [15:0]      fold2;
  logic [LEN_W-1:0] len_d;
  rec_t             rec_d;
  logic [LEN_W-1:0] rep_len_d;

  always_comb begin
    fold1 = {1'b0, fin_sum[31:16]} + {1'b0, fin_sum[15:0]};
    fold2 = 16'(fold1[15:0] + {15'h0, fold1[16]});
    len_d = fin_len + (fin_cls.fcs ? LEN_W'(4) : LEN_W'(0));
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_comb begin
      rec_d[w] = rec[w];
      if (fin_vld) begin
        case (w)
          2:       rec_d[w] = {30'h0, fin_cls.mcast & fin_cls.ipmc, fin_cls.mcast};
          3:       rec_d[w] = {fold2, 16'h0};
          4:       rec_d[w] = {{(WORD_W-LEN_W){1'b0}}, len_d};
          default: rec_d[w] = '0;
        endcase
      end
    end
  end

  always_comb rep_len_d = fin_vld ? len_d : rep_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_vld <= 1'b0;
      rec     <= '0;
      rep_len <= '0;
    end else begin
      rec_vld <= fin_vld;
      rec     <= rec_d;
      rep_len <= rep_len_d;
    end
  end

  // R7
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_vld |=> $stable(rec));

  // R5
  fcs_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_vld && fin_cls.fcs |=> rep_len == $past(fin_len) + LEN_W'(4));
endmodule

// File: rtl/rxcs_bytecnt.sv
module rxcs_bytecnt
  import rxcs_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [LEN_W-1:0] add_val,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (add_en) cnt_d = cnt + CNT_W'(add_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(cnt));
endmodule

// File: rtl/rxcs_status_gen.sv
module rxcs_status_gen
  import rxcs_pkg::*;
#(
  parameter int BUF_BYTES = 4096,
  parameter int HDR_BYTES = 14,
  parameter int CNT_W     = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_mcast,
  input  logic        in_ipmcast,
  input  logic        fcs_inband,
  output logic        stat_valid,
  output logic [31:0] stat_w0,
  output logic [31:0] stat_w1,
  output logic [31:0] stat_w2,
  output logic [31:0] stat_w3,
  output logic [31:0] stat_w4,
  output logic        rx_cmplt,
  output logic [31:0] rx_bytes_lo,
  output logic [31:0] rx_bytes_hi
);
  localparam int CAP = BUF_BYTES - 4;

  rx_class_t        cls_in;
  logic             fin_vld;
  logic [ACC_W-1:0] fin_sum;
  logic [LEN_W-1:0] fin_len;
  rx_class_t        fin_cls;
  logic             rec_vld;
  rec_t             rec;
  logic [LEN_W-1:0] rep_len;
  logic             cmplt_q, cmplt_d;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    cls_in.mcast = in_mcast;
    cls_in.ipmc  = in_ipmcast;
    cls_in.fcs   = fcs_inband;
  end

  rxcs_sum #(.BUF_BYTES(BUF_BYTES), .HDR_BYTES(HDR_BYTES)) sum_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .cls_in(cls_in), .fin_vld(fin_vld),
    .fin_sum(fin_sum), .fin_len(fin_len), .fin_cls(fin_cls)
  );

  rxcs_fold fold_i (
    .clk(clk), .rst_n(rst_n), .fin_vld(fin_vld), .fin_sum(fin_sum),
    .fin_len(fin_len), .fin_cls(fin_cls), .rec_vld(rec_vld),
    .rec(rec), .rep_len(rep_len)
  );

  rxcs_bytecnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .add_en(rec_vld), .add_val(rep_len),
    .cnt(cnt)
  );

  always_comb cmplt_d = rec_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmplt_q <= 1'b0;
    else        cmplt_q <= cmplt_d;
  end

  assign stat_valid  = rec_vld;
  assign stat_w0     = rec[0];
  assign stat_w1     = rec[1];
  assign stat_w2     = rec[2];
  assign stat_w3     = rec[3];
  assign stat_w4     = rec[4];
  assign rx_cmplt    = cmplt_q;
  assign rx_bytes_lo = cnt[31:0];
  assign rx_bytes_hi = 32'(cnt >> 32);

  // R4
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> stat_w4[15:0] <= 16'(CAP + 4));

  // R6
  ipmc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid && !stat_w2[0] |-> !stat_w2[1]);

  // R7
  cmplt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cmplt |-> $past(stat_valid));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid && in_last, 2));
endmodule

// File: tb/rxcs_status_gen_tb_top.sv
`timescale 1ns/1ps
module rxcs_status_gen_tb_top;
  localparam int BUF = 64;
  localparam int CAP = BUF - 4;

  typedef struct {
    int          due;
    logic [31:0] w2;
    logic [31:0] w3;
    logic [31:0] w4;
  } exp_t;

  logic clk, rst_n, in_valid, in_last, in_mcast, in_ipmcast, fcs_inband;
  logic [7:0] in_data;
  logic stat_valid, rx_cmplt;
  logic [31:0] stat_w0, stat_w1, stat_w2, stat_w3, stat_w4, rx_bytes_lo, rx_bytes_hi;

  int n_chk, n_fail, cyc;
  bit mon_en, finished;
  exp_t q[$];
  logic [63:0] ref_cnt;
  logic [15:0] pend_len;
  bit pend;
  logic [7:0] fb [0:127];

  rxcs_status_gen #(.BUF_BYTES(BUF)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_mcast(in_mcast), .in_ipmcast(in_ipmcast),
    .fcs_inband(fcs_inband), .stat_valid(stat_valid), .stat_w0(stat_w0),
    .stat_w1(stat_w1), .stat_w2(stat_w2), .stat_w3(stat_w3),
    .stat_w4(stat_w4), .rx_cmplt(rx_cmplt), .rx_bytes_lo(rx_bytes_lo),
    .rx_bytes_hi(rx_bytes_hi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Cycle-by-cycle comparison against the reference schedule
  always @(negedge clk) begin
    if (mon_en) begin
      if (pend) ref_cnt = ref_cnt + 64'(pend_len);
      chk("R7 rx_cmplt", 64'(rx_cmplt), 64'(pend));
      chk("R8 byte count", {rx_bytes_hi, rx_bytes_lo}, ref_cnt);
      pend = 1'b0;
      if (q.size() > 0 && q[0].due == cyc) begin
        chk("R7 stat_valid", 64'(stat_valid), 64'd1);
        chk("R6 word0", 64'(stat_w0), 64'd0);
        chk("R6 word1", 64'(stat_w1), 64'd0);
        chk("R6 word2 class", 64'(stat_w2), 64'(q[0].w2));
        chk("R1 R2 R3 word3 checksum", 64'(stat_w3), 64'(q[0].w3));
        chk("R4 R5 word4 length", 64'(stat_w4), 64'(q[0].w4));
        pend = 1'b1;
        pend_len = q[0].w4[15:0];
        void'(q.pop_front());
      end else begin
        chk("R7 no stray stat_valid", 64'(stat_valid), 64'd0);
      end
    end
  end

  task automatic send_frame(input int n, input bit mc, input bit ipm, input bit fcs, input int gap);
    exp_t e;
    int stored;
    logic [31:0] s;
    stored = (n < CAP) ? n : CAP;
    s = 0;
    for (int i = 14; i < stored; i++) begin
      if (((i - 14) % 2) == 0) s = s + (32'(fb[i]) << 8);
      else                     s = s + 32'(fb[i]);
    end
    s = (s & 32'hFFFF) + (s >> 16);
    s = (s & 32'hFFFF) + (s >> 16);
    e.w2 = {30'h0, mc & ipm, mc};
    e.w3 = {s[15:0], 16'h0};
    e.w4 = 32'(stored + (fcs ? 4 : 0));
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_data    = fb[i];
      in_last    = (i == n - 1);
      in_mcast   = mc;
      in_ipmcast = ipm;
      fcs_inband = fcs;
      if (i == n - 1) begin
        e.due = cyc + 2;
        q.push_back(e);
      end
    end
    if (gap > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < 128; i++) fb[i] = 8'((i * 37 + seed) & 255);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; mon_en = 0; finished = 0;
    ref_cnt = 0; pend = 0; pend_len = 0;
    rst_n = 1'b0; in_valid = 0; in_data = 0; in_last = 0;
    in_mcast = 0; in_ipmcast = 0; fcs_inband = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 stat_valid", 64'(stat_valid), 64'd0);
    chk("R9 rx_cmplt", 64'(rx_cmplt), 64'd0);
    chk("R9 words", {stat_w0 | stat_w1 | stat_w2, stat_w3 | stat_w4}, 64'd0);
    chk("R9 byte count", {rx_bytes_hi, rx_bytes_lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;

    fill(0, 3);   send_frame(20, 0, 0, 0, 3);   // R1 even payload
    fill(0, 11);  send_frame(21, 1, 0, 0, 2);   // R2 odd trailing byte, R6 mcast
    fill(0, 5);   send_frame(33, 1, 1, 0, 2);   // R2 R6 ip multicast
    fill(0, 7);   send_frame(25, 0, 1, 0, 2);   // R6 ipmc without mcast
    fill(0, 9);   send_frame(40, 0, 0, 1, 2);   // R5 fcs in band
    fill(0, 1);   send_frame(14, 0, 0, 0, 2);   // R10 header only
    fill(0, 2);   send_frame(5, 1, 1, 1, 2);    // R10 short frame
    fill(0, 4);   send_frame(100, 0, 0, 0, 2);  // R4 truncation
    fill(0, 6);   send_frame(CAP, 0, 0, 1, 2);  // R4 exactly at cap
    fill(0, 8);   send_frame(CAP + 1, 1, 0, 0, 2); // R4 one past cap
    // R3 double fold: pairs FFFF FFFF 0001
    for (int i = 0; i < 14; i++) fb[i] = 8'h55;
    fb[14] = 8'hFF; fb[15] = 8'hFF; fb[16] = 8'hFF; fb[17] = 8'hFF;
    fb[18] = 8'h00; fb[19] = 8'h01;
    send_frame(20, 0, 0, 0, 2);
    // R10 back-to-back frames with no gap
    fill(0, 13);  send_frame(18, 1, 0, 0, 0);
    fill(0, 17);  send_frame(27, 0, 0, 1, 0);
    fill(0, 19);  send_frame(2, 1, 1, 0, 0);
    fill(0, 23);  send_frame(64, 0, 0, 0, 6);
    repeat (6) @(negedge clk);
    chk("R7 all records seen", 64'(q.size()), 64'd0);
    summary();
  end
endmodule